// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Cycle Sequencer

This block runs one bus cycle at a time on a 16-bit bus where address and data share the same lines. The core presents a request: a 20-bit address, read or write, memory or I/O space, byte or word width, a two-bit segment tag and the write data. The block latches the request and steps through T1, T2, T3, any number of wait states (Tw) and T4. In T4 it raises `done` for one clock, with the read data available on `rdata`.

The block drives the address latch strobe, read and write strobes, data enable, transfer direction, the memory/I/O indicator and the high-byte enable, so that external latches and transceivers can separate address from data. The four upper address lines carry address bits 19:16 in T1 and a status word from T2 to T4. The slave stretches a cycle by holding `ready` low. Another bus master can ask for the bus on `hold`. The block finishes its current cycle, releases every bus and control output, and reports this on `hlda`. Instead of tristate drivers, each group of outputs has its own output-enable.

Top module: `mux_bus_seq`

## Requirements
- R1: After reset, and in idle, `ale`=0, `rd_n`=`wr_n`=`den_n`=`bhe_n`=1, `ad_oe`=`hi_oe`=0, `ctl_oe`=1, `hlda`=0, `done`=0.
- R2: A request seen with `req_valid`=1 at a clock edge while idle starts T1 on that edge. The cycle then lasts 4 clocks plus one per wait state, and `done` is high only in T4.
- R3: `ale` is high for exactly one clock, in T1, while `ad_out` carries address bits 15:0 with `ad_oe`=1.
- R4: `rd_n` is low in T2, T3 and Tw of a read. `wr_n` is low in T2, T3 and Tw of a write. The two are never low together.
- R5: In a write, `ad_out` holds the write data with `ad_oe`=1 from T2 through T4. In a read, `ad_oe`=0 after T1.
- R6: `bhe_n` is 0 for the whole cycle when the transfer is a word or a byte at an odd address. It is 1 for a byte at an even address. Word requests use even addresses.
- R7: In T1, `hi_out` equals address bits 19:16 for memory cycles and 0 for I/O cycles. In T2 through T4 it equals {2'b00, segment tag}.
- R8: `ready` is sampled at the end of T3 and at the end of each Tw. Each low sample adds one Tw, and the first high sample leads to T4.
- R9: Read data is captured from `ad_in` on the edge where `ready` is sampled high. It is presented on `rdata` in T4 together with a one-clock `done`.
- R10: `den_n` is low from T2 through T4. `dt_r` is 1 for writes and 0 for reads, from T1 through T4.
- R11: `mio` is 1 for a memory cycle and 0 for an I/O cycle, from T1 through T4.
- R12: `hold` passes through a two-flop synchronizer. A cycle in progress completes. `hlda` rises on the third edge after `hold` rises, or at the end of T4 if later. While `hlda`=1, `ctl_oe`, `ad_oe` and `hi_oe` are 0 and requests are not accepted. `hlda` falls on the third edge after `hold` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Core request; held until `done` |
| req_addr | input | 20 | Cycle address |
| req_write | input | 1 | 1 write, 0 read |
| req_mem | input | 1 | 1 memory, 0 I/O |
| req_byte | input | 1 | 1 byte, 0 word |
| req_seg | input | 2 | Segment tag for status |
| req_wdata | input | 16 | Write data |
| done | output | 1 | One-clock completion pulse in T4 |
| rdata | output | 16 | Captured read data |
| ad_out | output | 16 | Shared address/data lines, driven value |
| ad_oe | output | 1 | Enable for `ad_out` |
| ad_in | input | 16 | Shared lines, received value |
| hi_out | output | 4 | Upper address / status lines |
| hi_oe | output | 1 | Enable for `hi_out` |
| bhe_n | output | 1 | High-byte enable, active low |
| ale | output | 1 | Address latch strobe |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| den_n | output | 1 | Data enable for transceivers, active low |
| dt_r | output | 1 | Transceiver direction, 1 = transmit |
| mio | output | 1 | 1 memory, 0 I/O |
| ctl_oe | output | 1 | Enable for control outputs |
| ready | input | 1 | Slave ready; low inserts wait states |
| hold | input | 1 | Asynchronous bus request from another master |
| hlda | output | 1 | Bus released acknowledge |

## Verification
Every bus output is decoded from the state register, so it changes one edge after the decision that causes it. T1 appears one edge after the request is seen. Each following phase appears one edge later, with one extra edge for every low `ready` sample. The bench drives inputs and samples outputs on the falling edge, and it walks the phases in step with the design. It predicts each phase's outputs from the request fields and the wait count it chose. The synchronizer delay of three edges is checked at both the rise and the fall of `hlda`, both in idle and after `hold` arrives during T2.

// File: rtl/mux_bus_seq.sv
module mux_bus_seq #(
  parameter int DW   = 16,
  parameter int AW   = 20,
  parameter int SYNC = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [AW-1:0] req_addr,
  input  logic          req_write,
  input  logic          req_mem,
  input  logic          req_byte,
  input  logic [1:0]    req_seg,
  input  logic [DW-1:0] req_wdata,
  output logic          done,
  output logic [DW-1:0] rdata,
  output logic [DW-1:0] ad_out,
  output logic          ad_oe,
  input  logic [DW-1:0] ad_in,
  output logic [AW-DW-1:0] hi_out,
  output logic          hi_oe,
  output logic          bhe_n,
  output logic          ale,
  output logic          rd_n,
  output logic          wr_n,
  output logic          den_n,
  output logic          dt_r,
  output logic          mio,
  output logic          ctl_oe,
  input  logic          ready,
  input  logic          hold,
  output logic          hlda
);

  localparam int HW = AW - DW;

  typedef enum logic [2:0] {S_IDLE, S_T1, S_T2, S_T3, S_TW, S_T4, S_HOLD} st_t;

  st_t st, nx;
  logic [SYNC-1:0] hsync;
  logic            hold_s;
  logic [AW-1:0]   r_addr;
  logic [DW-1:0]   r_wdata;
  logic [1:0]      r_seg;
  logic            r_write, r_mem, r_byte;

  assign hold_s = hsync[SYNC-1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) hsync <= '0;
    else        hsync <= {hsync[SYNC-2:0], hold};

  always_comb begin
    nx = st;
    case (st)
      S_IDLE: if (hold_s) nx = S_HOLD; else if (req_valid) nx = S_T1;
      S_T1:   nx = S_T2;
      S_T2:   nx = S_T3;
      S_T3,
      S_TW:   nx = ready ? S_T4 : S_TW;
      S_T4:   nx = hold_s ? S_HOLD : S_IDLE;
      S_HOLD: if (!hold_s) nx = S_IDLE;
      default: nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) st <= S_IDLE;
    else        st <= nx;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      r_addr  <= '0;
      r_wdata <= '0;
      r_seg   <= '0;
      r_write <= 1'b0;
      r_mem   <= 1'b0;
      r_byte  <= 1'b0;
    end else if (st == S_IDLE && nx == S_T1) begin
      r_addr  <= req_addr;
      r_wdata <= req_wdata;
      r_seg   <= req_seg;
      r_write <= req_write;
      r_mem   <= req_mem;
      r_byte  <= req_byte;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) rdata <= '0;
    else if ((st == S_T3 || st == S_TW) && ready && !r_write) rdata <= ad_in;

  logic in_t1, mid, data_ph, active;
  assign in_t1   = (st == S_T1);
  assign mid     = (st == S_T2) || (st == S_T3) || (st == S_TW);
  assign data_ph = mid || (st == S_T4);
  assign active  = in_t1 || data_ph;

  assign ale    = in_t1;
  assign ad_oe  = in_t1 || (data_ph && r_write);
  assign ad_out = in_t1 ? r_addr[DW-1:0] : r_wdata;
  assign hi_oe  = active;
  assign hi_out = in_t1 ? (r_mem ? r_addr[AW-1:DW] : '0) : HW'(r_seg);
  assign bhe_n  = !(active && (!r_byte || r_addr[0]));
  assign rd_n   = !(mid && !r_write);
  assign wr_n   = !(mid && r_write);
  assign den_n  = !data_ph;
  assign dt_r   = r_write;
  assign mio    = r_mem;
  assign ctl_oe = (st != S_HOLD);
  assign hlda   = (st == S_HOLD);
  assign done   = (st == S_T4);

endmodule

module mux_bus_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic ale,
  input logic rd_n,
  input logic wr_n,
  input logic dt_r,
  input logic done,
  input logic ready,
  input logic hold,
  input logic hlda,
  input logic ctl_oe,
  input logic ad_oe,
  input logic hi_oe
);
  p_ale_single_r3: assert property (@(posedge clk) disable iff (!rst_n) ale |=> !ale);
  p_strobe_excl_r4: assert property (@(posedge clk) disable iff (!rst_n) !(!rd_n && !wr_n));
  p_rd_follows_ale_r4: assert property (@(posedge clk) disable iff (!rst_n) (ale && !dt_r) |=> !rd_n);
  p_wait_keeps_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n) (!rd_n && !ready) |=> !rd_n);
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  p_float_r12: assert property (@(posedge clk) disable iff (!rst_n) hlda |-> (!ctl_oe && !ad_oe && !hi_oe));
  p_sync_delay_r12: assert property (@(posedge clk) disable iff (!rst_n) (!hlda && $rose(hold)) |=> !hlda);
endmodule

bind mux_bus_seq mux_bus_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ale(ale), .rd_n(rd_n), .wr_n(wr_n), .dt_r(dt_r),
  .done(done), .ready(ready), .hold(hold), .hlda(hlda), .ctl_oe(ctl_oe),
  .ad_oe(ad_oe), .hi_oe(hi_oe)
);

// File: tb/mux_bus_seq_test.sv
module mux_bus_seq_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 0, req_write = 0, req_mem = 0, req_byte = 0;
  logic [19:0] req_addr = '0;
  logic [1:0]  req_seg = '0;
  logic [15:0] req_wdata = '0, ad_in = '0;
  logic ready = 1'b1, hold = 1'b0;
  logic done, ad_oe, hi_oe, bhe_n, ale, rd_n, wr_n, den_n, dt_r, mio, ctl_oe, hlda;
  logic [15:0] rdata, ad_out;
  logic [3:0]  hi_out;
  int checks = 0, errs = 0;

  always #4 clk = ~clk;

  mux_bus_seq uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_write(req_write), .req_mem(req_mem), .req_byte(req_byte), .req_seg(req_seg),
    .req_wdata(req_wdata), .done(done), .rdata(rdata), .ad_out(ad_out), .ad_oe(ad_oe),
    .ad_in(ad_in), .hi_out(hi_out), .hi_oe(hi_oe), .bhe_n(bhe_n), .ale(ale),
    .rd_n(rd_n), .wr_n(wr_n), .den_n(den_n), .dt_r(dt_r), .mio(mio), .ctl_oe(ctl_oe),
    .ready(ready), .hold(hold), .hlda(hlda)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errs++;
      $display("FAIL %s got %0h exp %0h", tag, got, exp);
    end
  endtask

  function automatic logic exp_bhe(input logic byt, input logic a0);
    return !(!byt || a0);
  endfunction

  task automatic chk_idle(input string tag);
    chk({tag, " ale"}, ale, 0);
    chk({tag, " rd_n"}, rd_n, 1);
    chk({tag, " wr_n"}, wr_n, 1);
    chk({tag, " den_n"}, den_n, 1);
    chk({tag, " bhe_n"}, bhe_n, 1);
    chk({tag, " oe"}, {ad_oe, hi_oe, ctl_oe}, 3'b001);
    chk({tag, " hlda"}, hlda, 0);
    chk({tag, " done"}, done, 0);
  endtask

  task automatic run_cycle(input logic [19:0] a, input logic wr, input logic mem,
                           input logic byt, input logic [1:0] seg, input logic [15:0] wd,
                           input int waits, input logic [15:0] rdv, input bit hold_t2);
    logic [3:0] stat;
    stat = {2'b00, seg};
    @(negedge clk);
    req_addr = a; req_write = wr; req_mem = mem; req_byte = byt;
    req_seg = seg; req_wdata = wd; req_valid = 1; ready = 1;
    @(negedge clk);
    chk("R3 ale in T1", ale, 1);
    chk("R3 address", {ad_oe, ad_out}, {1'b1, a[15:0]});
    chk("R7 upper T1", hi_out, mem ? a[19:16] : 4'h0);
    chk("R6 bhe_n", bhe_n, exp_bhe(byt, a[0]));
    chk("R11 mio", mio, mem);
    chk("R10 dt_r", dt_r, wr);
    chk("R4 strobes T1", {rd_n, wr_n, den_n}, 3'b111);
    req_valid = 0;
    for (int ph = 0; ph < 2; ph++) begin
      @(negedge clk);
      chk("R3 ale low", ale, 0);
      chk("R4 rd_n", rd_n, wr);
      chk("R4 wr_n", wr_n, !wr);
      chk("R10 den_n", den_n, 0);
      chk("R7 status", hi_out, stat);
      chk("R6 bhe_n held", bhe_n, exp_bhe(byt, a[0]));
      chk("R5 ad_oe", ad_oe, wr);
      if (wr) chk("R5 wdata", ad_out, wd);
      chk("R2 no early done", done, 0);
      if (ph == 0 && hold_t2) hold = 1;
      if (ph == 1) begin
        ready = (waits == 0);
        ad_in = (waits == 0) ? rdv : 16'hDEAD;
      end
    end
    for (int i = 0; i < waits; i++) begin
      @(negedge clk);
      chk("R8 wait strobe", {rd_n, wr_n}, wr ? 2'b10 : 2'b01);
      chk("R8 no done in Tw", done, 0);
      chk("R11 mio in Tw", mio, mem);
      ready = (i == waits - 1);
      ad_in = ready ? rdv : 16'hBEEF;
    end
    @(negedge clk);
    chk("R2 done in T4", done, 1);
    chk("R4 strobes off T4", {rd_n, wr_n}, 2'b11);
    chk("R10 den_n T4", den_n, 0);
    chk("R5 ad_oe T4", ad_oe, wr);
    if (wr) chk("R5 wdata T4", ad_out, wd);
    else chk("R9 rdata", rdata, rdv);
    chk("R12 no hlda in T4", hlda, 0);
    ready = 1; ad_in = 16'h5A5A;
    @(negedge clk);
    if (hold_t2) begin
      chk("R12 hlda", hlda, 1);
      chk("R12 float", {ctl_oe, ad_oe, hi_oe}, 3'b000);
      hold = 0;
      @(negedge clk); chk("R12 hlda kept 1", hlda, 1);
      @(negedge clk); chk("R12 hlda kept 2", hlda, 1);
      @(negedge clk); chk("R12 hlda drop", hlda, 0);
      chk("R12 ctl back", ctl_oe, 1);
    end else begin
      chk_idle("R1 idle after");
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errs++;
    $display("FAIL watchdog expired got running exp finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, errs);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (2) @(negedge clk);
    chk_idle("R1 reset");
    rst_n = 1;
    @(negedge clk);
    chk_idle("R1 after reset");

    run_cycle(20'hA1234, 0, 1, 0, 2'b10, 16'h0, 0, 16'h1357, 0);
    run_cycle(20'h00F31, 1, 0, 1, 2'b01, 16'hC3A5, 2, 16'h0, 0);
    run_cycle(20'h5_6788, 0, 1, 1, 2'b00, 16'h0, 3, 16'hFACE, 0);
    run_cycle(20'hF0002, 1, 1, 0, 2'b11, 16'h9876, 1, 16'h0, 1);

    // R12: hold taken in idle, requests ignored while held
    @(negedge clk); hold = 1;
    @(negedge clk); chk("R12 sync edge1", hlda, 0);
    @(negedge clk); chk("R12 sync edge2", hlda, 0);
    @(negedge clk); chk("R12 granted idle", hlda, 1);
    req_valid = 1; req_addr = 20'h11110; req_write = 0; req_mem = 1; req_byte = 0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk("R12 request ignored", {ale, hlda}, 2'b01);
    end
    req_valid = 0; hold = 0;
    repeat (3) @(negedge clk);
    chk_idle("R12 released");

    for (int k = 0; k < 40; k++) begin
      logic [19:0] a;
      logic byt;
      a = 20'($urandom);
      byt = 1'($urandom);
      if (!byt) a[0] = 1'b0;
      run_cycle(a, 1'($urandom), 1'($urandom), byt, 2'($urandom), 16'($urandom),
                int'($urandom % 4), 16'($urandom), (k % 9) == 4);
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, errs);
    $finish;
  end
endmodule